// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block sits beside a processor core, on the system side. It turns the core's low-power requests into a controlled entry to a quiescent state and a controlled exit from it. The core raises one of three level requests: doze, nap or sleep. The sequencer picks one of them, asserts either the halt or the stop input of the core, and waits for the matching acknowledgement.

Each mode then applies its own policy:

- **Doze** keeps every clock running.
- **Nap** gates the core clock but keeps the time base counting.
- **Sleep** gates the core clock and also freezes the time base.

A single wakeup indication from the core undoes whichever mode is active. The clocks come back first, and the core is released one cycle later.

Both enables come from dedicated flops, so a downstream clock gate only sees changes on a clock edge. After every wakeup, the block stays idle until the requests have been seen low. This keeps a stale request from sending the core straight back down.

Top module: `pwr_mode_seq`

## Requirements
- R1: During and directly after reset, `core_halt` and `core_stop` are 0 and `core_clk_en` and `core_tb_en` are 1.
- R2: When armed and idle, a sampled request starts entry on the same edge. Priority is sleep over nap over doze. Doze asserts `core_halt`; nap or sleep asserts `core_stop`. Either output is visible one cycle after the request is sampled.
- R3: In doze, once `core_halted` has been sampled high, `core_clk_en` and `core_tb_en` both stay 1.
- R4: In nap, `core_clk_en` drops one cycle after `core_stopped` is sampled high, while `core_tb_en` stays 1.
- R5: In sleep, `core_clk_en` and `core_tb_en` drop together, one cycle after `core_stopped` is sampled high. `core_tb_en` is never 0 while `core_clk_en` is 1.
- R6: The core clock is never gated before the stop acknowledgement is seen. While the acknowledgement is absent, `core_clk_en` stays 1.
- R7: When `core_wakeup` is sampled in the low-power state, both enables return to 1 one cycle later. `core_halt` or `core_stop` drops one cycle after that.
- R8: After release, the block returns to idle once the acknowledgement is sampled low. No new entry starts until all requests have been sampled low for `QUIET_CYC` consecutive idle cycles. The same rule applies after reset.
- R9: `core_halt` and `core_stop` are never both 1. A wakeup seen while waiting for the acknowledgement abandons the entry without ever gating a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_doze | input | 1 | Core requests doze (halt, clocks kept) |
| req_nap | input | 1 | Core requests nap (stop, time base kept) |
| req_sleep | input | 1 | Core requests sleep (stop, time base frozen) |
| core_halted | input | 1 | Core acknowledges it is halted |
| core_stopped | input | 1 | Core acknowledges it is stopped |
| core_wakeup | input | 1 | Core reports a pending interrupt or debug request |
| core_halt | output | 1 | Halt request to the core |
| core_stop | output | 1 | Stop request to the core |
| core_clk_en | output | 1 | Registered enable for the core clock gate |
| core_tb_en | output | 1 | Registered time-base enable |

## Verification
Every output of this block is a flop, and the block reacts to inputs sampled at a clock edge. Each response therefore appears one cycle after the edge that sampled its cause:

- halt or stop follows a request by one cycle;
- clock gating follows the acknowledgement by one cycle;
- the enables follow wakeup by one cycle;
- release follows the enables by one more cycle.

The bench applies each stimulus on the falling edge. For every cycle it queues the output values due after the next rising edge. A monitor compares them 5 ns after that edge, so each result is checked in exactly the cycle the requirements name.

// File: rtl/pms_pkg.sv
// Shared types for the low-power mode sequencer.
// Assumes three request lines, indexed doze=0, nap=1, sleep=2; a higher index wins.
package pms_pkg;

    localparam int PMS_NUM_REQ = 3;

    typedef enum logic [1:0] {
        MODE_NONE  = 2'd0,
        MODE_DOZE  = 2'd1,
        MODE_NAP   = 2'd2,
        MODE_SLEEP = 2'd3
    } pms_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_WAIT_ACK = 3'd1,
        ST_LOW      = 3'd2,
        ST_RESTORE  = 3'd3,
        ST_DRAIN    = 3'd4
    } pms_state_e;

endpackage

// File: rtl/pms_prio.sv
// Priority picker: turns the request vector into one mode.
// Assumes bit i of req maps to mode value i+1, and the highest set bit wins.
module pms_prio
    import pms_pkg::*;
#(
    parameter int NUM_REQ = PMS_NUM_REQ
) (
    input  logic [NUM_REQ-1:0] req,
    output pms_mode_e          mode
);

    // Scan from low to high so that the highest asserted request is kept last.
    always_comb begin
        mode = MODE_NONE;
        for (int i = 0; i < NUM_REQ; i++) begin
            if (req[i]) mode = pms_mode_e'(2'(i + 1));
        end
    end

endmodule

// File: rtl/pms_rearm.sv
// Re-arm tracker: allows a new entry only after the requests have been quiet
// for QUIET_CYC consecutive idle cycles.
// Assumes 'idle' is high only while the controller is in its idle state.
module pms_rearm #(
    parameter int QUIET_CYC = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic idle,
    input  logic any_req,
    output logic armed
);

    localparam int CW = $clog2(QUIET_CYC + 1);
    localparam logic [CW-1:0] QUIET_MAX = CW'(QUIET_CYC);

    logic [CW-1:0] quiet_cnt;

    assign armed = (quiet_cnt == QUIET_MAX);

    // Count consecutive quiet idle cycles; clear outside idle or on an early request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quiet_cnt <= '0;
        end else if (!idle) begin
            quiet_cnt <= '0;
        end else if (any_req) begin
            if (!armed) quiet_cnt <= '0;
        end else if (!armed) begin
            quiet_cnt <= quiet_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/pms_ctrl.sv
// Entry and exit controller: drives halt or stop, then gates the clock and the time base
// according to the latched mode, and undoes it all on wakeup.
// Assumes the inputs are synchronous to clk; all outputs are flops for glitch-free gating.
module pms_ctrl
    import pms_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  pms_mode_e mode_req,
    input  logic      armed,
    input  logic      halted,
    input  logic      stopped,
    input  logic      wakeup,
    output logic      halt_o,
    output logic      stop_o,
    output logic      clk_en_o,
    output logic      tb_en_o,
    output logic      idle_o
);

    pms_state_e st;
    pms_mode_e  mode_q;
    logic       ack;

    // Acknowledgement that belongs to the latched mode.
    assign ack    = (mode_q == MODE_DOZE) ? halted : stopped;
    assign idle_o = (st == ST_IDLE);

    // State machine with registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            mode_q   <= MODE_NONE;
            halt_o   <= 1'b0;
            stop_o   <= 1'b0;
            clk_en_o <= 1'b1;
            tb_en_o  <= 1'b1;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (armed && mode_req != MODE_NONE) begin
                        mode_q <= mode_req;
                        halt_o <= (mode_req == MODE_DOZE);
                        stop_o <= (mode_req != MODE_DOZE);
                        st     <= ST_WAIT_ACK;
                    end
                end
                ST_WAIT_ACK: begin
                    if (wakeup) begin
                        st <= ST_RESTORE;
                    end else if (ack) begin
                        if (mode_q != MODE_DOZE)  clk_en_o <= 1'b0;
                        if (mode_q == MODE_SLEEP) tb_en_o  <= 1'b0;
                        st <= ST_LOW;
                    end
                end
                ST_LOW: begin
                    if (wakeup) begin
                        clk_en_o <= 1'b1;
                        tb_en_o  <= 1'b1;
                        st       <= ST_RESTORE;
                    end
                end
                ST_RESTORE: begin
                    halt_o <= 1'b0;
                    stop_o <= 1'b0;
                    st     <= ST_DRAIN;
                end
                ST_DRAIN: begin
                    if (!ack) begin
                        mode_q <= MODE_NONE;
                        st     <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pwr_mode_seq.sv
// Low-power mode sequencer top: picks a mode from the core's requests, places the core in
// halt or stop, gates its clock and time base, and restores everything on wakeup.
// Assumes all inputs are synchronous to clk and the reset is synchronous, active low.
module pwr_mode_seq
    import pms_pkg::*;
#(
    parameter int QUIET_CYC = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_doze,
    input  logic req_nap,
    input  logic req_sleep,
    input  logic core_halted,
    input  logic core_stopped,
    input  logic core_wakeup,
    output logic core_halt,
    output logic core_stop,
    output logic core_clk_en,
    output logic core_tb_en
);

    logic [PMS_NUM_REQ-1:0] req_vec;
    pms_mode_e              mode_req;
    logic                   armed;
    logic                   idle;

    // Gather the requests in priority order, lowest first.
    assign req_vec = {req_sleep, req_nap, req_doze};

    pms_prio #(.NUM_REQ(PMS_NUM_REQ)) i_prio (
        .req  (req_vec),
        .mode (mode_req)
    );

    pms_rearm #(.QUIET_CYC(QUIET_CYC)) i_rearm (
        .clk     (clk),
        .rst_n   (rst_n),
        .idle    (idle),
        .any_req (|req_vec),
        .armed   (armed)
    );

    pms_ctrl i_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_req (mode_req),
        .armed    (armed),
        .halted   (core_halted),
        .stopped  (core_stopped),
        .wakeup   (core_wakeup),
        .halt_o   (core_halt),
        .stop_o   (core_stop),
        .clk_en_o (core_clk_en),
        .tb_en_o  (core_tb_en),
        .idle_o   (idle)
    );

endmodule

// File: rtl/pms_seq_chk.sv
// Protocol checker for the sequencer ports, attached to every pwr_mode_seq instance.
// Assumes the synchronous active-low reset of the design.
module pms_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic req_doze,
    input logic req_nap,
    input logic req_sleep,
    input logic core_halted,
    input logic core_stopped,
    input logic core_wakeup,
    input logic core_halt,
    input logic core_stop,
    input logic core_clk_en,
    input logic core_tb_en
);

    // R9
    halt_stop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(core_halt && core_stop));

    // R6
    gate_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_clk_en) |-> ($past(core_stopped) && core_stop));

    // R5
    tb_under_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !core_tb_en |-> !core_clk_en);

    // R5
    tb_falls_with_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_tb_en) |-> $fell(core_clk_en));

    // R7
    clocks_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_clk_en) |-> ($past(core_wakeup) && core_stop));

    // R7
    release_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(core_halt) || $fell(core_stop)) |-> (core_clk_en && core_tb_en && $past(core_clk_en)));

    // R2
    doze_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_halt) |-> ($past(req_doze) && !$past(req_nap) && !$past(req_sleep)));

    // R2
    stop_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_stop) |-> ($past(req_nap) || $past(req_sleep)));

endmodule

bind pwr_mode_seq pms_seq_chk i_pms_seq_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_doze     (req_doze),
    .req_nap      (req_nap),
    .req_sleep    (req_sleep),
    .core_halted  (core_halted),
    .core_stopped (core_stopped),
    .core_wakeup  (core_wakeup),
    .core_halt    (core_halt),
    .core_stop    (core_stop),
    .core_clk_en  (core_clk_en),
    .core_tb_en   (core_tb_en)
);

// File: tb/test_pwr_mode_seq.sv
// Scoreboard bench: each driver step queues the outputs due after the next rising edge,
// and a monitor compares them 5 ns after that edge.
module test_pwr_mode_seq;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_doze = 1'b0, req_nap = 1'b0, req_sleep = 1'b0;
    logic core_halted = 1'b0, core_stopped = 1'b0, core_wakeup = 1'b0;
    logic core_halt, core_stop, core_clk_en, core_tb_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [3:0] outs; // {halt, stop, clk_en, tb_en}
        string      tag;
    } exp_t;

    exp_t sb_q[$];

    always #10 clk = ~clk; // 50 MHz

    pwr_mode_seq i_pwr_mode_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_doze     (req_doze),
        .req_nap      (req_nap),
        .req_sleep    (req_sleep),
        .core_halted  (core_halted),
        .core_stopped (core_stopped),
        .core_wakeup  (core_wakeup),
        .core_halt    (core_halt),
        .core_stop    (core_stop),
        .core_clk_en  (core_clk_en),
        .core_tb_en   (core_tb_en)
    );

    function automatic void compare(input logic [3:0] exp_v, input string tag);
        logic [3:0] act;
        act = {core_halt, core_stop, core_clk_en, core_tb_en};
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s: {halt,stop,clk_en,tb_en} actual %b expected %b", tag, act, exp_v);
        end
    endfunction

    // Driver: apply inputs on the falling edge and queue the outputs due after the next rising edge.
    task automatic step(input logic [2:0] req, input logic hd, input logic sp,
                        input logic wk, input logic [3:0] exp_v, input string tag);
        exp_t e;
        @(negedge clk);
        {req_sleep, req_nap, req_doze} = req;
        core_halted  = hd;
        core_stopped = sp;
        core_wakeup  = wk;
        e.outs = exp_v;
        e.tag  = tag;
        sb_q.push_back(e);
    endtask

    // Monitor: pop one expected item 5 ns after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                compare(e.outs, e.tag);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #5;
        compare(4'b0011, "R1 in reset");
        @(negedge clk);
        rst_n = 1'b1;
        // inputs {sleep,nap,doze}, halted, stopped, wakeup, expected {h,s,c,t}
        step(3'b000, 0, 0, 0, 4'b0011, "R1 after reset");
        // doze
        step(3'b001, 0, 0, 0, 4'b1011, "R2 doze enters halt");
        step(3'b001, 0, 0, 0, 4'b1011, "R6 doze waiting ack");
        step(3'b001, 1, 0, 0, 4'b1011, "R3 doze ack clocks kept");
        step(3'b001, 1, 0, 0, 4'b1011, "R3 doze low state");
        step(3'b001, 1, 0, 1, 4'b1011, "R7 doze wakeup");
        step(3'b001, 1, 0, 0, 4'b0011, "R7 doze halt released");
        step(3'b001, 1, 0, 0, 4'b0011, "R8 drain waits ack");
        step(3'b001, 0, 0, 0, 4'b0011, "R8 back to idle");
        step(3'b001, 0, 0, 0, 4'b0011, "R8 stale request ignored");
        step(3'b000, 0, 0, 0, 4'b0011, "R8 quiet cycle");
        // nap with doze also asserted
        step(3'b011, 0, 0, 0, 4'b0111, "R2 nap beats doze");
        step(3'b011, 0, 0, 0, 4'b0111, "R6 nap clock kept before ack");
        step(3'b010, 0, 1, 0, 4'b0101, "R4 nap clock gated tb kept");
        step(3'b010, 0, 1, 0, 4'b0101, "R4 nap low state");
        step(3'b000, 0, 1, 1, 4'b0111, "R7 nap wakeup clocks back");
        step(3'b000, 0, 1, 0, 4'b0011, "R7 nap stop released");
        step(3'b000, 0, 0, 0, 4'b0011, "R8 nap idle");
        step(3'b000, 0, 0, 0, 4'b0011, "R8 nap quiet");
        // sleep with all requests asserted
        step(3'b111, 0, 0, 0, 4'b0111, "R2 sleep beats nap and doze");
        step(3'b100, 1, 1, 0, 4'b0100, "R5 sleep gates clock and tb");
        step(3'b100, 0, 1, 0, 4'b0100, "R5 sleep low state");
        step(3'b100, 0, 1, 1, 4'b0111, "R7 sleep wakeup");
        step(3'b100, 0, 1, 0, 4'b0011, "R7 sleep stop released");
        step(3'b000, 0, 0, 0, 4'b0011, "R8 sleep idle");
        step(3'b000, 0, 0, 0, 4'b0011, "R8 sleep quiet");
        // doze with a stop acknowledgement must not gate
        step(3'b001, 0, 0, 0, 4'b1011, "R2 doze again");
        step(3'b001, 0, 1, 0, 4'b1011, "R6 wrong ack ignored");
        step(3'b001, 0, 1, 0, 4'b1011, "R6 still waiting halted");
        // wakeup while waiting for the ack
        step(3'b001, 0, 0, 1, 4'b1011, "R9 wakeup during ack wait");
        step(3'b000, 0, 0, 0, 4'b0011, "R9 released without gating");
        step(3'b000, 0, 0, 0, 4'b0011, "R9 idle");
        step(3'b100, 0, 0, 0, 4'b0011, "R8 not armed after abort");
        step(3'b000, 0, 0, 0, 4'b0011, "R8 quiet after abort");
        step(3'b100, 0, 0, 0, 4'b0111, "R2 sleep entry");
        step(3'b100, 0, 0, 1, 4'b0111, "R9 sleep aborted");
        step(3'b100, 0, 0, 0, 4'b0011, "R9 stop dropped clocks untouched");
        step(3'b000, 0, 0, 0, 4'b0011, "R8 final idle");
        while (sb_q.size() > 0) @(posedge clk);
        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule